// File: doc/BRIEF.md
# UART Interrupt Enable and Request Unit

This block turns the status levels and event pulses of a UART core into one interrupt request line for the processor. Software programs an 8-bit enable register over a simple register bus. Each enable bit is combined with its own source condition. A level from the processor then gates the OR of all enabled conditions, and the result is registered before it leaves the block.

The block also owns the shared data location of the bus map. A write there loads the transmit holding register and sends a load strobe to the core. A read there returns the byte the core presents as received data, and the same read acknowledges the receive-data interrupt. Transfers from holding register to shift register and the three line errors are held in flags inside the block. The errors stay set until software writes the clear location.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, `irq` is 0, `txHold` is 0x00 and `txLoad` is 0.
- R2: The enable register sits at offset 0x4. It is read/write, and a read returns the last value written.
- R3: A write to offset 0x0 loads `txHold` with the write data and raises `txLoad` for exactly one cycle. A read of offset 0x0 returns `rxHold`.
- R4: Enable bit 0 (receive data) requests while an `rxLoad` pulse has not yet been followed by a read of offset 0x0, or while `rxTrigger` is high. That read ends the unread-data part.
- R5: Enable bit 1 (holding register moved) requests after a `thrXfer` pulse. The pending flag clears on a write to offset 0x0 and is held clear while bit 1 is 0.
- R6: Enable bit 7 (transmitter idle) requests only while `thrEmpty` and `tsrEmpty` are both high.
- R7: Enable bit 6 requests while `rxTimeout` is high. Enable bit 2 requests while `rxBreak` is high.
- R8: Enable bits 5, 4 and 3 map to the parity, framing and overrun error pulses. Each pulse sets a sticky flag, and only a write to offset 0x8 clears it. If a pulse and the clear land in the same cycle, the flag stays set.
- R9: While `cpuIntEn` is low, `irq` is 0 one cycle later, whatever the sources and enables are.
- R10: `irq` follows the enabled conditions with one register of delay. A source whose enable bit is 0 has no effect on `irq`.
- R11: Reads of offset 0x8 and of unmapped offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte offset of the access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| rxHold | input | 8 | Received byte from the core |
| rxLoad | input | 1 | Pulse: new byte placed in the receive holding register |
| rxTrigger | input | 1 | Receive FIFO fill at or above trigger level |
| rxTimeout | input | 1 | Receive timeout has expired |
| rxBreak | input | 1 | Break condition present on the line |
| parityErr | input | 1 | Pulse: parity error |
| frameErr | input | 1 | Pulse: framing error |
| overrunErr | input | 1 | Pulse: overrun error |
| thrEmpty | input | 1 | Transmit holding register empty |
| tsrEmpty | input | 1 | Transmit shift register empty |
| thrXfer | input | 1 | Pulse: holding register moved into shift register |
| cpuIntEn | input | 1 | Processor global interrupt enable |
| txHold | output | 8 | Transmit holding register contents |
| txLoad | output | 1 | One-cycle strobe after a data write |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench turns on one enable bit at a time and drives the matching source, then repeats with the source active and its bit off. This separates a wrong bit mapping from a missing gate. For transmitter idle it raises each empty flag alone and then both, which exposes an OR in place of the required AND. The pulse sources are checked across a wait and then across their own clearing access (data read, data write, disable, clear write), so sticky and pending behaviour can be told apart from plain level following. Toggling `cpuIntEn` with a request active shows that the global gate is applied last.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int DATA_W  = 8;
  localparam int NUM_SRC = 8;
  localparam int NUM_ERR = 3;

  // enable bit positions (software-visible)
  localparam int SRC_RXH = 0;
  localparam int SRC_THR = 1;
  localparam int SRC_BRK = 2;
  localparam int SRC_OVR = 3;
  localparam int SRC_FRM = 4;
  localparam int SRC_PAR = 5;
  localparam int SRC_TMO = 6;
  localparam int SRC_TXE = 7;

  typedef struct packed {
    logic enWr;    // write enable register
    logic thrWr;   // write data location
    logic rhrRd;   // read data location
    logic stsClr;  // write clear location
    logic rdData;  // read mux selects data
    logic rdIen;   // read mux selects enable register
  } strobe_t;
endpackage

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] rxHold,
  output logic [DATA_W-1:0] enReg,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] txHold,
  output logic              txLoad
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= '0;
      txHold <= '0;
      txLoad <= 1'b0;
    end else begin
      if (strb.enWr)  enReg  <= busWdata;
      if (strb.thrWr) txHold <= busWdata;
      txLoad <= strb.thrWr;
    end
  end

  always_comb begin
    busRdata = '0;
    if (strb.rdData)     busRdata = rxHold;
    else if (strb.rdIen) busRdata = enReg;
  end

  // R2: enable register only changes on its write strobe
  a_r2_en_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.enWr |=> $stable(enReg));
  // R3: load strobe only follows a data write
  a_r3_txload_src: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |-> $past(strb.thrWr));
endmodule

// File: rtl/uart_irq_control.sv
module uart_irq_control
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int OFF_DATA = 0,
  parameter int OFF_IEN  = 4,
  parameter int OFF_CLR  = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] enReg,
  input  logic              rxLoad,
  input  logic              rxTrigger,
  input  logic              rxTimeout,
  input  logic              rxBreak,
  input  logic              parityErr,
  input  logic              frameErr,
  input  logic              overrunErr,
  input  logic              thrEmpty,
  input  logic              tsrEmpty,
  input  logic              thrXfer,
  input  logic              cpuIntEn,
  output strobe_t           strb,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] ADR_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] ADR_IEN  = ADDR_W'(OFF_IEN);
  localparam logic [ADDR_W-1:0] ADR_CLR  = ADDR_W'(OFF_CLR);

  logic hitData, hitIen, hitClr;
  assign hitData = busSel && (busAddr == ADR_DATA);
  assign hitIen  = busSel && (busAddr == ADR_IEN);
  assign hitClr  = busSel && (busAddr == ADR_CLR);

  always_comb begin
    strb        = '0;
    strb.enWr   = hitIen  &&  busWrite;
    strb.thrWr  = hitData &&  busWrite;
    strb.rhrRd  = hitData && !busWrite;
    strb.stsClr = hitClr  &&  busWrite;
    strb.rdData = hitData && !busWrite;
    strb.rdIen  = hitIen  && !busWrite;
  end

  // pending flags
  logic rxPend, thrPend;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPend  <= 1'b0;
      thrPend <= 1'b0;
    end else begin
      if (rxLoad)          rxPend <= 1'b1;
      else if (strb.rhrRd) rxPend <= 1'b0;
      if (!enReg[SRC_THR]) thrPend <= 1'b0;
      else if (thrXfer)    thrPend <= 1'b1;
      else if (strb.thrWr) thrPend <= 1'b0;
    end
  end

  // sticky line errors: index 0 overrun, 1 framing, 2 parity
  logic [NUM_ERR-1:0] errPulse, errFlag;
  assign errPulse = {parityErr, frameErr, overrunErr};

  for (genvar g = 0; g < NUM_ERR; g++) begin : gErr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                errFlag[g] <= 1'b0;
      else if (errPulse[g])     errFlag[g] <= 1'b1;
      else if (strb.stsClr)     errFlag[g] <= 1'b0;
    end
    // R8: a set flag survives until the clear write
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
      errFlag[g] && !strb.stsClr |=> errFlag[g]);
  end

  logic [NUM_SRC-1:0] cond;
  always_comb begin
    cond          = '0;
    cond[SRC_RXH] = rxPend || rxTrigger;
    cond[SRC_THR] = thrPend;
    cond[SRC_BRK] = rxBreak;
    cond[SRC_OVR] = errFlag[0];
    cond[SRC_FRM] = errFlag[1];
    cond[SRC_PAR] = errFlag[2];
    cond[SRC_TMO] = rxTimeout;
    cond[SRC_TXE] = thrEmpty && tsrEmpty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= cpuIntEn && |(enReg[NUM_SRC-1:0] & cond);
  end

  // R5: pending transfer flag is held clear while disabled
  a_r5_thr_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enReg[SRC_THR] |=> !thrPend);
  // R9: global gate
  a_r9_gate: assert property (@(posedge clk) disable iff (!rstN)
    !cpuIntEn |=> !irq);
  // R10: nothing enabled, nothing requested
  a_r10_no_enable: assert property (@(posedge clk) disable iff (!rstN)
    (enReg == '0) |=> !irq);
  // R4: unread data flag only rises on a load pulse
  a_r4_rx_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxPend) |-> $past(rxLoad));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int OFF_DATA = 0,
  parameter int OFF_IEN  = 4,
  parameter int OFF_CLR  = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] rxHold,
  input  logic              rxLoad,
  input  logic              rxTrigger,
  input  logic              rxTimeout,
  input  logic              rxBreak,
  input  logic              parityErr,
  input  logic              frameErr,
  input  logic              overrunErr,
  input  logic              thrEmpty,
  input  logic              tsrEmpty,
  input  logic              thrXfer,
  input  logic              cpuIntEn,
  output logic [DATA_W-1:0] txHold,
  output logic              txLoad,
  output logic              irq
);
  strobe_t           strb;
  logic [DATA_W-1:0] enReg;

  uart_irq_control #(
    .ADDR_W(ADDR_W), .OFF_DATA(OFF_DATA), .OFF_IEN(OFF_IEN), .OFF_CLR(OFF_CLR)
  ) uCtl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .enReg(enReg), .rxLoad(rxLoad), .rxTrigger(rxTrigger),
    .rxTimeout(rxTimeout), .rxBreak(rxBreak), .parityErr(parityErr),
    .frameErr(frameErr), .overrunErr(overrunErr), .thrEmpty(thrEmpty),
    .tsrEmpty(tsrEmpty), .thrXfer(thrXfer), .cpuIntEn(cpuIntEn),
    .strb(strb), .irq(irq)
  );

  uart_irq_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .rxHold(rxHold), .enReg(enReg), .busRdata(busRdata),
    .txHold(txHold), .txLoad(txLoad)
  );

  // R11: clear location and holes read as zero
  a_r11_clr_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWrite && (busAddr == ADDR_W'(OFF_CLR)) |-> busRdata == '0);
endmodule

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 0, busWrite = 0;
  logic [3:0] busAddr = 0;
  logic [7:0] busWdata = 0, rxHold = 0;
  logic       rxLoad = 0, rxTrigger = 0, rxTimeout = 0, rxBreak = 0;
  logic       parityErr = 0, frameErr = 0, overrunErr = 0;
  logic       thrEmpty = 0, tsrEmpty = 0, thrXfer = 0, cpuIntEn = 0;
  logic [7:0] busRdata, txHold;
  logic       txLoad, irq;

  always #2.5 clk = ~clk;

  uart_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rxHold(rxHold), .rxLoad(rxLoad), .rxTrigger(rxTrigger),
    .rxTimeout(rxTimeout), .rxBreak(rxBreak), .parityErr(parityErr),
    .frameErr(frameErr), .overrunErr(overrunErr), .thrEmpty(thrEmpty),
    .tsrEmpty(tsrEmpty), .thrXfer(thrXfer), .cpuIntEn(cpuIntEn),
    .txHold(txHold), .txLoad(txLoad), .irq(irq)
  );

  typedef struct {
    int         kind;   // 0 irq, 1 busRdata, 2 txHold, 3 txLoad
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int nRun = 0, nFail = 0;
  bit done = 0;

  // monitor: compares queued expectations 1 ns after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = {7'b0, irq};
          1: act = busRdata;
          2: act = txHold;
          default: act = {7'b0, txLoad};
        endcase
        nRun++;
        if (act !== it.exp) begin
          nFail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic push(int kind, logic [7:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expIrq(bit e, string tag);
    push(0, {7'b0, e}, tag);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic busWr(logic [3:0] a, logic [7:0] d);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic busRd(logic [3:0] a, logic [7:0] e, string tag);
    busSel = 1; busWrite = 0; busAddr = a;
    push(1, e, tag);
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    push(0, 8'h00, "R1 irq after reset");
    push(2, 8'h00, "R1 txHold after reset");
    push(3, 8'h00, "R1 txLoad after reset");
    @(negedge clk);
    busRd(4'h4, 8'h00, "R1 enable reg reset");

    // R2 read/write
    busWr(4'h4, 8'hA5);
    busRd(4'h4, 8'hA5, "R2 enable readback A5");
    busWr(4'h4, 8'h5A);
    busRd(4'h4, 8'h5A, "R2 enable readback 5A");
    busWr(4'h4, 8'h00);

    // R10 all level sources on, nothing enabled
    cpuIntEn = 1;
    thrEmpty = 1; tsrEmpty = 1; rxTimeout = 1; rxBreak = 1; rxTrigger = 1;
    settle();
    expIrq(0, "R10 disabled sources ignored");
    thrEmpty = 0; tsrEmpty = 0; rxTimeout = 0; rxBreak = 0; rxTrigger = 0;

    // R6 transmitter idle needs both empties
    busWr(4'h4, 8'h80);
    thrEmpty = 1; settle();
    expIrq(0, "R6 only holding empty");
    thrEmpty = 0; tsrEmpty = 1; settle();
    expIrq(0, "R6 only shift empty");
    thrEmpty = 1; settle();
    expIrq(1, "R6 both empty");
    // R9 global gate
    cpuIntEn = 0; settle();
    expIrq(0, "R9 global enable low");
    cpuIntEn = 1; settle();
    expIrq(1, "R9 global enable restored");
    thrEmpty = 0; tsrEmpty = 0;

    // R7 timeout and break
    busWr(4'h4, 8'h40);
    rxBreak = 1; settle();
    expIrq(0, "R7 break with only timeout enabled");
    rxBreak = 0; rxTimeout = 1; settle();
    expIrq(1, "R7 timeout");
    rxTimeout = 0;
    busWr(4'h4, 8'h04);
    rxBreak = 1; settle();
    expIrq(1, "R7 break");
    rxBreak = 0; settle();
    expIrq(0, "R7 break removed");

    // R4 receive data
    busWr(4'h4, 8'h01);
    rxHold = 8'h3C;
    pulse(rxLoad);
    repeat (5) @(negedge clk);
    expIrq(1, "R4 unread data pending");
    busRd(4'h0, 8'h3C, "R3 data read returns rxHold");
    settle();
    expIrq(0, "R4 read acknowledges");
    rxTrigger = 1; settle();
    expIrq(1, "R4 trigger level");
    rxTrigger = 0; settle();
    expIrq(0, "R4 trigger removed");

    // R5 holding moved into shift register
    busWr(4'h4, 8'h02);
    pulse(thrXfer);
    repeat (4) @(negedge clk);
    expIrq(1, "R5 transfer pending");
    busWr(4'h0, 8'h77);
    push(3, 8'h01, "R3 txLoad pulse");
    push(2, 8'h77, "R3 txHold loaded");
    @(negedge clk);
    push(3, 8'h00, "R3 txLoad single cycle");
    @(negedge clk);
    expIrq(0, "R5 write clears pending");
    pulse(thrXfer);
    settle();
    expIrq(1, "R5 pending again");
    busWr(4'h4, 8'h00);
    busWr(4'h4, 8'h02);
    settle();
    expIrq(0, "R5 disable cleared pending");

    // R8 sticky errors
    busWr(4'h4, 8'h08);
    pulse(parityErr);
    settle();
    expIrq(0, "R8 parity not mapped to bit 3");
    busWr(4'h4, 8'h20);
    settle();
    expIrq(1, "R8 parity sticky on bit 5");
    repeat (10) @(negedge clk);
    expIrq(1, "R8 parity still held");
    busWr(4'h8, 8'h00);
    settle();
    expIrq(0, "R8 clear write");
    busWr(4'h4, 8'h10);
    pulse(frameErr);
    settle();
    expIrq(1, "R8 framing on bit 4");
    busWr(4'h8, 8'h00);
    busWr(4'h4, 8'h08);
    pulse(overrunErr);
    settle();
    expIrq(1, "R8 overrun on bit 3");
    // pulse and clear in the same cycle: set wins
    busWr(4'h8, 8'h00);
    settle();
    overrunErr = 1; busSel = 1; busWrite = 1; busAddr = 4'h8;
    @(negedge clk);
    overrunErr = 0; busSel = 0; busWrite = 0;
    settle();
    expIrq(1, "R8 set wins over clear");
    busWr(4'h8, 8'h00);
    settle();
    expIrq(0, "R8 cleared afterwards");

    // R11 clear location and hole read zero
    busRd(4'h8, 8'h00, "R11 clear location reads zero");
    busRd(4'hC, 8'h00, "R11 unmapped reads zero");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule